// File: doc/BRIEF.md
# NAND page ECC syndrome corrector

This block checks a 256-byte flash sector, or a 512-byte page treated as two 256-byte halves, against its stored error-correction codes. Each half has a 22-bit code. Bits 10:0 hold a set of line and column parities, and bits 21:11 hold the complement set. The block takes a code computed from the data read back and the code kept in the spare area. It XORs the two into a syndrome and sorts the result into one of four classes: clean, corrupt stored code, correctable single-bit data error, or uncorrectable error.

When a half holds a correctable error, the block repairs the data buffer itself. It reads the failing byte once over a byte-wide synchronous buffer port, inverts the failing bit and writes the byte back. A single start strobe begins a check. The per-half class and the error location are held until the next start. A one-cycle done pulse marks the point where every half has been classified and repaired.

Top module: `nand_ecc_corrector`

## Requirements
- R1: A half whose syndrome (calculated XOR stored) is zero, or whose calculated code or stored code is all zero, reports status 2'b00 (clean) and causes no buffer access.
- R2: A half whose syndrome has exactly one bit set reports status 2'b01 (stored code corrupt), leaves the buffer untouched and raises `any_error`.
- R3: A half whose syndrome has exactly eleven bits set, and where (calc[10:0]^calc[21:11])^(stored[10:0]^stored[21:11]) equals 11'h7FF, reports status 2'b10 (corrected). It reports `fail_byte` = syndrome[10:3] and `fail_bit` = syndrome[2:0], and it does not raise `any_error` for that half.
- R4: Any other nonzero syndrome reports status 2'b11 (uncorrectable), makes no buffer access and raises `any_error`.
- R5: For each corrected half, the buffer sees exactly one read and then, in the next cycle, one write to address {half, fail_byte}. The write data is the byte that was read with bit `fail_bit` inverted. No other buffer access takes place.
- R6: With `wide_page` high at start, half 1 is checked as well, its buffer addresses are offset by 256, and `any_error` is the OR of both halves. With `wide_page` low, half 1 reports status 2'b00 whatever its codes are.
- R7: Status and location outputs are valid after the clock edge that samples `start`. `done` is a single-cycle pulse that rises N edges after that edge, where N is the number of halves checked plus twice the number of corrected halves.
- R8: A `start` that arrives while a check is in progress is ignored: the held results, the buffer traffic and the done timing are unchanged.
- R9: After reset, `done`, `any_error`, both buffer strobes and all statuses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check; sampled only when idle |
| wide_page | input | 1 | 1: 512-byte page (two halves), 0: one 256-byte sector |
| calc_code | input | 2x22 | Code computed from the data, per half |
| stored_code | input | 2x22 | Code read from the spare area, per half |
| half_status | output | 2x2 | Per-half class: 00 clean, 01 code corrupt, 10 corrected, 11 uncorrectable |
| fail_byte | output | 2x8 | Failing byte index within the half |
| fail_bit | output | 2x3 | Failing bit within that byte |
| any_error | output | 1 | Some checked half is code-corrupt or uncorrectable |
| done | output | 1 | One-cycle pulse when the check and any repair are complete |
| buf_rd_en | output | 1 | Buffer byte read strobe |
| buf_wr_en | output | 1 | Buffer byte write strobe |
| buf_addr | output | 9 | Buffer byte address |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Byte returned one cycle after a read strobe |

## Verification
The hardest case to reach is a page where both halves need repair. The block then runs two back-to-back read-modify-write pairs, and the second must land 256 bytes higher while the first result stays held. A case nearly as hard is a syndrome with exactly eleven bits set whose parity pairs do not all disagree. The stimulus table lists each half as a calculated code plus an intended syndrome, with syndromes built as {~L, L} from a chosen byte and bit, so these patterns can be chosen on purpose. A behavioural buffer in the bench then confirms that the right bit flipped and that the count of reads and writes is exact. A second start pulse injected in the middle of a repair checks that the block ignores it.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int PAR_W      = 11;
    localparam int CODE_W     = 2 * PAR_W;
    localparam int BIT_IDX_W  = 3;
    localparam int BYTE_IDX_W = PAR_W - BIT_IDX_W;
    localparam int NUM_HALVES = 2;
    localparam int HALF_W     = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;
    localparam int BUF_AW     = HALF_W + BYTE_IDX_W;

    typedef enum logic [1:0] {
        ST_CLEAN      = 2'b00,
        ST_CODE_FAULT = 2'b01,
        ST_FIXED      = 2'b10,
        ST_UNCORR     = 2'b11
    } half_status_t;

    typedef struct packed {
        half_status_t              status;
        logic [BYTE_IDX_W-1:0]     byte_idx;
        logic [BIT_IDX_W-1:0]      bit_idx;
    } half_result_t;

    function automatic int unsigned ones_in_code(input logic [CODE_W-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < CODE_W; i++) n += int'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/ecc_half_classifier.sv
module ecc_half_classifier
    import nand_ecc_pkg::*;
(
    input  logic [CODE_W-1:0] calc,
    input  logic [CODE_W-1:0] stored,
    output half_result_t      res
);
    logic [CODE_W-1:0] synd;
    logic [PAR_W-1:0]  calc_fold;
    logic [PAR_W-1:0]  stored_fold;
    int unsigned       weight;

    always_comb begin
        synd        = calc ^ stored;
        calc_fold   = calc[PAR_W-1:0] ^ calc[CODE_W-1:PAR_W];
        stored_fold = stored[PAR_W-1:0] ^ stored[CODE_W-1:PAR_W];
        weight      = ones_in_code(synd);
        res         = '0;
        if (synd == '0 || calc == '0 || stored == '0) begin
            res.status = ST_CLEAN;
        end else if (weight == 1) begin
            res.status = ST_CODE_FAULT;
        end else if (weight == PAR_W &&
                     (calc_fold ^ stored_fold) == {PAR_W{1'b1}}) begin
            res.status   = ST_FIXED;
            res.byte_idx = synd[PAR_W-1:BIT_IDX_W];
            res.bit_idx  = synd[BIT_IDX_W-1:0];
        end else begin
            res.status = ST_UNCORR;
        end
    end
endmodule

// File: rtl/ecc_fix_sequencer.sv
module ecc_fix_sequencer
    import nand_ecc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              launch,
    input  logic                              wide_q,
    input  half_result_t [NUM_HALVES-1:0]     res,
    input  logic [7:0]                        buf_rdata,
    output logic                              idle,
    output logic                              done,
    output logic                              buf_rd_en,
    output logic                              buf_wr_en,
    output logic [BUF_AW-1:0]                 buf_addr,
    output logic [7:0]                        buf_wdata
);
    typedef enum logic [2:0] {S_IDLE, S_SCAN, S_READ, S_WRITE, S_FIN} seq_state_t;

    seq_state_t        state;
    logic [HALF_W-1:0] half;
    logic              last_half;

    assign last_half = (half == HALF_W'(wide_q ? NUM_HALVES - 1 : 0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            half  <= '0;
        end else begin
            case (state)
                S_IDLE: if (launch) begin
                    state <= S_SCAN;
                    half  <= '0;
                end
                S_SCAN: begin
                    if (res[half].status == ST_FIXED) state <= S_READ;
                    else if (last_half)               state <= S_FIN;
                    else                              half  <= half + 1'b1;
                end
                S_READ: state <= S_WRITE;
                S_WRITE: begin
                    if (last_half) state <= S_FIN;
                    else begin
                        state <= S_SCAN;
                        half  <= half + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign idle      = (state == S_IDLE);
    assign done      = (state == S_FIN);
    assign buf_rd_en = (state == S_READ);
    assign buf_wr_en = (state == S_WRITE);
    assign buf_addr  = {half, res[half].byte_idx};
    assign buf_wdata = buf_rdata ^ (8'b1 << res[half].bit_idx);

    // R5
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> $past(buf_rd_en));
    // R5
    rd_only_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        buf_rd_en |-> (res[half].status == ST_FIXED));
    // R5
    wr_addr_held_chk: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> $stable(buf_addr));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
    import nand_ecc_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  start,
    input  logic                                  wide_page,
    input  logic [NUM_HALVES-1:0][CODE_W-1:0]     calc_code,
    input  logic [NUM_HALVES-1:0][CODE_W-1:0]     stored_code,
    output logic [NUM_HALVES-1:0][1:0]            half_status,
    output logic [NUM_HALVES-1:0][BYTE_IDX_W-1:0] fail_byte,
    output logic [NUM_HALVES-1:0][BIT_IDX_W-1:0]  fail_bit,
    output logic                                  any_error,
    output logic                                  done,
    output logic                                  buf_rd_en,
    output logic                                  buf_wr_en,
    output logic [BUF_AW-1:0]                     buf_addr,
    output logic [7:0]                            buf_wdata,
    input  logic [7:0]                            buf_rdata
);
    half_result_t [NUM_HALVES-1:0] cls;
    half_result_t [NUM_HALVES-1:0] res_q;
    logic                          wide_q;
    logic                          seq_idle;
    logic [NUM_HALVES-1:0]         err_vec;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        ecc_half_classifier u_cls (
            .calc   (calc_code[h]),
            .stored (stored_code[h]),
            .res    (cls[h])
        );
        assign half_status[h] = res_q[h].status;
        assign fail_byte[h]   = res_q[h].byte_idx;
        assign fail_bit[h]    = res_q[h].bit_idx;
        assign err_vec[h]     = res_q[h].status[0];
    end

    assign any_error = |err_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            wide_q <= 1'b0;
        end else if (start && seq_idle) begin
            wide_q <= wide_page;
            for (int h = 0; h < NUM_HALVES; h++)
                res_q[h] <= (h == 0 || wide_page) ? cls[h] : '0;
        end
    end

    ecc_fix_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (start && seq_idle),
        .wide_q    (wide_q),
        .res       (res_q),
        .buf_rdata (buf_rdata),
        .idle      (seq_idle),
        .done      (done),
        .buf_rd_en (buf_rd_en),
        .buf_wr_en (buf_wr_en),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata)
    );

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !seq_idle |=> $stable(res_q));
    // R6
    narrow_half1_chk: assert property (@(posedge clk) disable iff (rst)
        !wide_q |-> (res_q[NUM_HALVES-1].status == ST_CLEAN));
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(buf_rd_en && buf_wr_en));
endmodule

// File: tb/nand_ecc_corrector_test.sv
module nand_ecc_corrector_test;
    import nand_ecc_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                              rst, start, wide_page;
    logic [NUM_HALVES-1:0][CODE_W-1:0] calc_code, stored_code;
    logic [NUM_HALVES-1:0][1:0]        half_status;
    logic [NUM_HALVES-1:0][7:0]        fail_byte;
    logic [NUM_HALVES-1:0][2:0]        fail_bit;
    logic                              any_error, done, buf_rd_en, buf_wr_en;
    logic [8:0]                        buf_addr;
    logic [7:0]                        buf_wdata, buf_rdata;

    nand_ecc_corrector uut (
        .clk(clk), .rst(rst), .start(start), .wide_page(wide_page),
        .calc_code(calc_code), .stored_code(stored_code),
        .half_status(half_status), .fail_byte(fail_byte), .fail_bit(fail_bit),
        .any_error(any_error), .done(done), .buf_rd_en(buf_rd_en),
        .buf_wr_en(buf_wr_en), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    // behavioural data buffer with one-cycle read latency
    logic [7:0] mem [512];
    logic       load_pat;
    int         rd_cnt, wr_cnt;

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'h5C ^ {i[8], 7'h13};
    endfunction

    always @(posedge clk) begin
        if (load_pat) begin
            for (int i = 0; i < 512; i++) mem[i] <= pat(i);
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            if (buf_rd_en) begin
                buf_rdata <= mem[buf_addr];
                rd_cnt    <= rd_cnt + 1;
            end
            if (buf_wr_en) begin
                mem[buf_addr] <= buf_wdata;
                wr_cnt        <= wr_cnt + 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wide;
        logic [21:0] c0, y0, c1, y1;
        logic [1:0]  e0, e1;
        logic        err;
        logic [7:0]  b0;
        logic [2:0]  t0;
        logic [7:0]  b1;
        logic [2:0]  t1;
    } vec_t;

    localparam logic [21:0] CA = 22'h12A5C3;
    localparam logic [21:0] CB = 22'h0ABCDE;
    localparam int NV = 14;
    // per half: calculated code and intended syndrome; stored = calc ^ syndrome
    localparam vec_t VECS [NV] = '{
        '{1'b0, CA, 22'h000000, CB, 22'h0, 2'b00, 2'b00, 1'b0, 8'h00, 3'd0, 8'h00, 3'd0}, // R1
        '{1'b0, CA, 22'h000020, CB, 22'h0, 2'b01, 2'b00, 1'b1, 8'h00, 3'd0, 8'h00, 3'd0}, // R2
        '{1'b0, CA, 22'h2962D3, CB, 22'h0, 2'b10, 2'b00, 1'b0, 8'h5A, 3'd3, 8'h00, 3'd0}, // R3
        '{1'b0, CA, 22'h000013, CB, 22'h0, 2'b11, 2'b00, 1'b1, 8'h00, 3'd0, 8'h00, 3'd0}, // R4
        '{1'b0, CA, 22'h000BFF, CB, 22'h0, 2'b11, 2'b00, 1'b1, 8'h00, 3'd0, 8'h00, 3'd0}, // R4
        '{1'b0, 22'h0, 22'h000013, CB, 22'h0, 2'b00, 2'b00, 1'b0, 8'h00, 3'd0, 8'h00, 3'd0}, // R1
        '{1'b0, CA, CA, CB, 22'h0, 2'b00, 2'b00, 1'b0, 8'h00, 3'd0, 8'h00, 3'd0},          // R1
        '{1'b0, CA, 22'h0007FF, CB, 22'h0, 2'b10, 2'b00, 1'b0, 8'hFF, 3'd7, 8'h00, 3'd0}, // R3
        '{1'b0, CA, 22'h3FF800, CB, 22'h0, 2'b10, 2'b00, 1'b0, 8'h00, 3'd0, 8'h00, 3'd0}, // R3
        '{1'b0, CA, 22'h000000, CB, 22'h2962D3, 2'b00, 2'b00, 1'b0, 8'h00, 3'd0, 8'h00, 3'd0}, // R6
        '{1'b1, CA, 22'h1F940D, CB, 22'h2962D3, 2'b10, 2'b10, 1'b0, 8'h81, 3'd5, 8'h5A, 3'd3}, // R6
        '{1'b1, CA, 22'h000000, CB, 22'h000013, 2'b00, 2'b11, 1'b1, 8'h00, 3'd0, 8'h00, 3'd0}, // R6
        '{1'b1, CA, 22'h200000, CB, 22'h000000, 2'b01, 2'b00, 1'b1, 8'h00, 3'd0, 8'h00, 3'd0}, // R6
        '{1'b1, CA, 22'h0007FF, CB, 22'h000BFF, 2'b10, 2'b11, 1'b1, 8'hFF, 3'd7, 8'h00, 3'd0}  // R6
    };

    task automatic run_vec(input vec_t v, input bit poke_busy);
        int lat;
        int fixes;
        int halves;
        @(negedge clk);
        load_pat = 1'b1;
        @(negedge clk);
        load_pat       = 1'b0;
        wide_page      = v.wide;
        calc_code[0]   = v.c0;
        stored_code[0] = v.c0 ^ v.y0;
        calc_code[1]   = v.c1;
        stored_code[1] = v.c1 ^ v.y1;
        start          = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R8: new codes and a start pulse in the middle of the check
            calc_code[0]   = CB;
            stored_code[0] = CB;
            start          = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat   = 1;
        end else lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        halves = v.wide ? 2 : 1;
        fixes  = int'(v.e0 == 2'b10) + int'(v.e1 == 2'b10);
        chk("R7 done latency", lat, halves + 2 * fixes);
        chk("R1-4 half0 status", half_status[0], v.e0);
        chk("R6 half1 status", half_status[1], v.e1);
        chk("R6 any_error", any_error, v.err);
        chk("R5 read count", rd_cnt, fixes);
        chk("R5 write count", wr_cnt, fixes);
        if (v.e0 == 2'b10) begin
            chk("R3 half0 byte", fail_byte[0], v.b0);
            chk("R3 half0 bit", fail_bit[0], v.t0);
            chk("R5 half0 repaired", mem[{1'b0, v.b0}], pat({1'b0, v.b0}) ^ (8'b1 << v.t0));
        end
        if (v.e1 == 2'b10) begin
            chk("R3 half1 byte", fail_byte[1], v.b1);
            chk("R3 half1 bit", fail_bit[1], v.t1);
            chk("R6 half1 repaired at +256", mem[{1'b1, v.b1}], pat({1'b1, v.b1}) ^ (8'b1 << v.t1));
        end
        @(negedge clk);
        chk("R7 done single pulse", done, 1'b0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; wide_page = 1'b0; load_pat = 1'b1;
        calc_code = '0; stored_code = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 done", done, 1'b0);
        chk("R9 any_error", any_error, 1'b0);
        chk("R9 strobes", {buf_rd_en, buf_wr_en}, 2'b00);
        chk("R9 status", half_status, '0);
        rst = 1'b0;
        load_pat = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);
        // R8: start ignored while busy, on one- and two-half repairs
        run_vec(VECS[2], 1'b1);
        run_vec(VECS[10], 1'b1);
        // R9: reset in the middle of a repair
        @(negedge clk);
        wide_page = 1'b1; calc_code[0] = CA; stored_code[0] = CA ^ 22'h1F940D;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 status after reset", half_status, '0);
        chk("R9 read strobe after reset", buf_rd_en, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule